// File: doc/BRIEF.md
# Write-Side Spill Slot for FIFO Full-Flag Extension

This block sits in the write clock domain, between a producer and the write port of an existing FIFO. The FIFO's own full flag is passed straight up to the producer as an early warning (almost-full). The block adds a single spill register behind that warning. While the FIFO reports room, producer writes go directly through and the spill register stays empty. If the producer writes once more while the FIFO is full, that item is parked in the spill register and the block's own full flag rises. This gives the producer one write of slack between the warning and the hard stop, and the FIFO's pointers and clock-domain crossing stay untouched.

As soon as the FIFO reports room again, the parked item is written into it first. This usually makes the FIFO full again, and the block's full flag then drops. The FIFO's full flag is released by read-side activity after synchronization, so it may stay high for many write cycles. The block holds its parked item for as long as that takes.

Back-pressure rules for the producer: a write is accepted in any cycle in which `full_o` is low. A write made while `full_o` is high is an overflow. It is discarded and latches `overflow_o` until reset. `almost_full_o` is advisory: after it rises, exactly one more write can be absorbed.

Top module: `wr_spill_guard`

## Requirements
- R1: When the spill register is empty (`full_o`=0) and `fifo_full_i`=0, a producer write drives `fifo_wr_o`=1 in the same cycle, with `fifo_data_o` equal to `wr_data_i`.
- R2: A producer write while `full_o`=0 and `fifo_full_i`=1 is not forwarded (`fifo_wr_o`=0). The item is stored, and `full_o` reads 1 from the next cycle.
- R3: While `full_o`=1 and `fifo_full_i`=0, `fifo_wr_o`=1 in that cycle, carrying the stored item, and `full_o` reads 0 from the next cycle.
- R4: While `full_o`=1 and `fifo_full_i` stays 1, the stored item is kept for any number of cycles, `fifo_wr_o` stays 0 and `full_o` stays 1.
- R5: `fifo_wr_o` is never 1 in a cycle in which `fifo_full_i`=1.
- R6: A producer write while `full_o`=1 is an overflow. It is never forwarded as producer data and does not replace the stored item. `overflow_o` reads 1 from the next cycle and stays 1 until reset.
- R7: With `AFULL_REG`=0, `almost_full_o` equals `fifo_full_i` in the same cycle. With `AFULL_REG`=1, it equals `fifo_full_i` from the previous cycle, and reads 0 in the first cycle after reset.
- R8: `rst` is synchronous and active high. After a cycle with `rst`=1, `full_o`=0, `overflow_o`=0 and the spill register is empty.
- R9: Items reach the FIFO in producer order. A stored item is written before any later producer item.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Producer write strobe |
| wr_data_i | input | DATA_W | Producer write data |
| fifo_full_i | input | 1 | Full flag from the downstream FIFO |
| fifo_wr_o | output | 1 | Write strobe to the FIFO |
| fifo_data_o | output | DATA_W | Write data to the FIFO |
| almost_full_o | output | 1 | Early warning to the producer (the FIFO's full flag) |
| full_o | output | 1 | Hard full to the producer (spill register occupied) |
| overflow_o | output | 1 | Sticky overflow error |

## Verification
The bench sweeps every four-cycle pattern of write strobe and FIFO full flag from reset, then runs a long pseudo-random phase in which a FIFO occupancy model releases its full flag after a random lag. Both settings of the almost-full parameter are checked side by side.

It targets these corner cases:
- A drain and an overflowing write in the same cycle. A design that let the producer data through here would break ordering.
- A full flag that stays high for dozens of cycles. A design that timed out would write into a full FIFO.
- A write in the very cycle the FIFO frees up while the spill register is occupied. A design that favoured the direct write would reorder data.
- Reset with the spill register occupied and the error latched. A design that missed this would leave stale data or a stuck full flag.

// File: rtl/wr_spill_pkg.sv
package wr_spill_pkg;

  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_HELD  = 1'b1
  } slot_state_e;

  typedef enum logic [1:0] {
    ACT_IDLE    = 2'd0,
    ACT_PASS    = 2'd1,
    ACT_CAPTURE = 2'd2,
    ACT_DRAIN   = 2'd3
  } slot_act_e;

endpackage

// File: rtl/spill_slot.sv
module spill_slot
  import wr_spill_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prod_we,
  input  logic [DATA_W-1:0] prod_data,
  input  logic              fifo_full,
  output logic              fifo_we,
  output logic [DATA_W-1:0] fifo_data,
  output logic              slot_held,
  output logic              overflow_hit
);

  slot_state_e       state_q;
  slot_state_e       state_d;
  slot_act_e         act;
  logic [DATA_W-1:0] hold_q;

  // Pick this cycle's action; a held entry always goes out before new data.
  always_comb begin
    act = ACT_IDLE;
    if (state_q == SLOT_HELD) begin
      if (!fifo_full) act = ACT_DRAIN;
    end else if (prod_we) begin
      act = fifo_full ? ACT_CAPTURE : ACT_PASS;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (act)
      ACT_CAPTURE: state_d = SLOT_HELD;
      ACT_DRAIN:   state_d = SLOT_EMPTY;
      default:     state_d = state_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SLOT_EMPTY;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      if (act == ACT_CAPTURE) hold_q <= prod_data;
    end
  end

  assign fifo_we      = (act == ACT_PASS) || (act == ACT_DRAIN);
  assign fifo_data    = (state_q == SLOT_HELD) ? hold_q : prod_data;
  assign slot_held    = (state_q == SLOT_HELD);
  assign overflow_hit = (state_q == SLOT_HELD) && prod_we;

endmodule

// File: rtl/afull_stage.sv
module afull_stage #(
  parameter bit REGISTERED = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic src_full,
  output logic afull
);

  generate
    if (REGISTERED) begin : g_reg
      logic af_q;
      always_ff @(posedge clk) begin
        if (rst) af_q <= 1'b0;
        else     af_q <= src_full;
      end
      assign afull = af_q;
    end else begin : g_comb
      logic unused_ctl;
      assign unused_ctl = clk ^ rst;
      assign afull      = src_full;
    end
  endgenerate

endmodule

// File: rtl/ovf_sticky.sv
module ovf_sticky (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic err
);

  logic err_q;

  always_ff @(posedge clk) begin
    if (rst)      err_q <= 1'b0;
    else if (hit) err_q <= 1'b1;
  end

  assign err = err_q;

endmodule

// File: rtl/wr_spill_guard.sv
module wr_spill_guard #(
  parameter int DATA_W    = 8,
  parameter bit AFULL_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              fifo_full_i,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              almost_full_o,
  output logic              full_o,
  output logic              overflow_o
);

  logic held;
  logic ovf_hit;

  spill_slot #(.DATA_W(DATA_W)) u_slot (
    .clk          (clk),
    .rst          (rst),
    .prod_we      (wr_en_i),
    .prod_data    (wr_data_i),
    .fifo_full    (fifo_full_i),
    .fifo_we      (fifo_wr_o),
    .fifo_data    (fifo_data_o),
    .slot_held    (held),
    .overflow_hit (ovf_hit)
  );

  afull_stage #(.REGISTERED(AFULL_REG)) u_af (
    .clk      (clk),
    .rst      (rst),
    .src_full (fifo_full_i),
    .afull    (almost_full_o)
  );

  ovf_sticky u_ovf (
    .clk (clk),
    .rst (rst),
    .hit (ovf_hit),
    .err (overflow_o)
  );

  assign full_o = held;

endmodule

// File: rtl/wr_spill_guard_chk.sv
module wr_spill_guard_chk #(
  parameter int DATA_W    = 8,
  parameter bit AFULL_REG = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              fifo_full_i,
  input logic              fifo_wr_o,
  input logic [DATA_W-1:0] fifo_data_o,
  input logic              almost_full_o,
  input logic              full_o,
  input logic              overflow_o
);

  assert_pass_through_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !full_o && !fifo_full_i) |-> (fifo_wr_o && fifo_data_o == wr_data_i));

  assert_capture_sets_full_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !full_o && fifo_full_i) |=> full_o);

  assert_drain_writes_R3: assert property (@(posedge clk) disable iff (rst)
    (full_o && !fifo_full_i) |-> fifo_wr_o);

  assert_drain_clears_full_R3: assert property (@(posedge clk) disable iff (rst)
    (full_o && !fifo_full_i) |=> !full_o);

  assert_hold_while_full_R4: assert property (@(posedge clk) disable iff (rst)
    (full_o && fifo_full_i) |=> full_o);

  assert_no_write_when_full_R5: assert property (@(posedge clk) disable iff (rst)
    fifo_full_i |-> !fifo_wr_o);

  assert_overflow_flagged_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && full_o) |=> overflow_o);

  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    overflow_o |=> overflow_o);

  assert_overflow_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow_o) |-> $past(wr_en_i && full_o));

  generate
    if (!AFULL_REG) begin : g_af_comb
      assert_afull_follows_R7: assert property (@(posedge clk) disable iff (rst)
        almost_full_o == fifo_full_i);
    end
  endgenerate

endmodule

bind wr_spill_guard wr_spill_guard_chk #(
  .DATA_W    (DATA_W),
  .AFULL_REG (AFULL_REG)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .fifo_full_i   (fifo_full_i),
  .fifo_wr_o     (fifo_wr_o),
  .fifo_data_o   (fifo_data_o),
  .almost_full_o (almost_full_o),
  .full_o        (full_o),
  .overflow_o    (overflow_o)
);

// File: tb/sim_wr_spill_guard.sv
`timescale 1ns/1ps
module sim_wr_spill_guard;

  localparam int DW    = 8;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          p_we = 1'b0;
  logic [DW-1:0] p_data = '0;
  logic          f_full = 1'b0;

  logic          fwe0, fwe1, af0, af1, full0, full1, ovf0, ovf1;
  logic [DW-1:0] fd0, fd1;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // model state
  bit            m_held = 0;
  logic [DW-1:0] m_hdata = '0;
  bit            m_ovf = 0;
  bit            m_af = 0;
  bit            prev_r = 1;
  bit            last_fwe = 0;

  always #2.5 clk = ~clk;

  wr_spill_guard #(.DATA_W(DW), .AFULL_REG(1'b0)) u0 (
    .clk(clk), .rst(rst), .wr_en_i(p_we), .wr_data_i(p_data), .fifo_full_i(f_full),
    .fifo_wr_o(fwe0), .fifo_data_o(fd0), .almost_full_o(af0), .full_o(full0), .overflow_o(ovf0));

  wr_spill_guard #(.DATA_W(DW), .AFULL_REG(1'b1)) u1 (
    .clk(clk), .rst(rst), .wr_en_i(p_we), .wr_data_i(p_data), .fifo_full_i(f_full),
    .fifo_wr_o(fwe1), .fifo_data_o(fd1), .almost_full_o(af1), .full_o(full1), .overflow_o(ovf1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit we, input logic [DW-1:0] d, input bit ff);
    bit            exp_we;
    logic [DW-1:0] exp_d;
    string         t_we, t_full;
    @(negedge clk);
    rst = r; p_we = we; p_data = d; f_full = ff;
    #1;
    exp_we = !ff && (m_held || (we != 0));
    exp_d  = m_held ? m_hdata : d;
    if (ff && m_held)  t_we = "R4";
    else if (ff)       t_we = "R5";
    else if (m_held)   t_we = "R3";
    else               t_we = "R1";
    t_full = prev_r ? "R8" : (m_held ? "R4" : "R2");
    chk(fwe0 == exp_we, t_we, fwe0, exp_we);
    if (exp_we)
      chk(fd0 == exp_d, m_held ? "R9" : "R1", fd0, exp_d);
    chk(full0 == m_held, t_full, full0, m_held);
    chk(ovf0 == m_ovf, prev_r ? "R8" : "R6", ovf0, m_ovf);
    chk(af0 == ff, "R7", af0, ff);
    chk(af1 == m_af, "R7", af1, m_af);
    chk(fwe1 == fwe0 && full1 == full0 && ovf1 == ovf0 && (!fwe0 || fd1 == fd0),
        "R7", {fwe1, full1, ovf1}, {fwe0, full0, ovf0});
    last_fwe = fwe0;
    @(posedge clk);
    prev_r = r;
    if (r) begin
      m_held = 0; m_ovf = 0; m_af = 0;
    end else begin
      if (we && m_held) m_ovf = 1;
      if (!m_held && ff && we) begin
        m_held = 1; m_hdata = d;
      end else if (m_held && !ff) begin
        m_held = 0;
      end
      m_af = ff;
    end
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] dcnt = 8'h01;
    logic [15:0]   lfsr = 16'hACE1;
    int            occ  = 0;
    int            lag  = 0;
    bit            ffv;

    step(1, 0, 0, 0);
    step(1, 0, 0, 0);

    // exhaustive 4-cycle patterns of (write, fifo full), each from reset
    for (int s = 0; s < 256; s++) begin
      step(1, 0, 0, 0);
      for (int c = 0; c < 4; c++) begin
        step(0, s[2*c], dcnt, s[2*c+1]);
        dcnt++;
      end
      step(0, 0, 0, 0);
      step(0, 1, dcnt, 1);
      dcnt++;
    end

    // long full: slot held for 40 cycles, then drain (R4, R3)
    step(1, 0, 0, 0);
    step(0, 1, 8'h5A, 1);
    for (int i = 0; i < 40; i++) step(0, 0, 8'hFF, 1);
    step(0, 0, 8'h00, 0);
    step(0, 0, 8'h00, 0);

    // reset with slot held and overflow latched (R8)
    step(0, 1, 8'h11, 1);
    step(0, 1, 8'h22, 1);
    step(1, 0, 8'h00, 1);
    step(0, 0, 8'h00, 0);

    // FIFO occupancy model with lagging full release
    step(1, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ffv = (occ >= DEPTH) || (lag != 0);
      step(0, lfsr[0] & (lfsr[1] | ~m_held), dcnt, ffv);
      dcnt++;
      if (last_fwe) occ++;
      chk(occ <= DEPTH, "R5", occ, DEPTH);
      if (lag != 0) lag--;
      if (occ > 0 && lfsr[2] && lfsr[3]) begin
        if (occ == DEPTH) lag = int'(lfsr[7:4]) % 6;
        occ--;
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule